// File: doc/BRIEF.md
# Sector Address Relocation Unit

This unit sits in the sector-address path between a host-side command interface and a block storage device. For each access request it looks up a small set of programmable relocation slots. Each slot covers a window of sectors, given by a first sector and a count, and names a base sector. When an accessed sector falls inside an enabled window, it is replaced by the base plus its distance from the window start. Sectors are 512 bytes, and every address is a whole-sector index. The translated address comes out one clock after the request, together with a flag. The flag tells the data path whether the translated sector lies in the programmed cipher range and so must pass through the cipher, or whether it is plain text.

Writes that land in a relocated window are tracked so that firmware can mark relocated copies as modified. The first such write raises a sticky interrupt and records the slot number. Later writes add per-slot pending bits until firmware clears the status. Slot 0 is normally used to divert the allocation-table region to an alternate copy, and the other slots overlay individual folders. All settings are held in a simple word-addressed register file written and read by a local processor.

Top module: `sector_remap_unit`

## Requirements
- R1: A request whose sector S satisfies start <= S < start+len for an enabled slot is output as base + (S - start), modulo 2^SECT_W.
- R2: A slot whose length register is zero never matches, whatever its start and base.
- R3: When several enabled slots match, the lowest-numbered slot supplies the translation and is the slot reported.
- R4: A request matching no enabled slot is output with its sector unchanged.
- R5: out_valid_o is high exactly in the cycle after a cycle with req_i high; out_sector_o and out_cipher_o are updated at that edge and hold their values while no request arrives.
- R6: out_cipher_o is 1 when the translated sector T satisfies cstart <= T < cstart+clen; a cipher length of zero marks every sector plain (0).
- R7: A write request (req_we_i=1) that matches a slot sets irq_o from the next cycle and records that slot in status; a read request never sets irq_o.
- R8: While irq_o is set, the recorded slot index is kept, irq_o stays high, and each further matching write sets the pending bit of its slot.
- R9: A register write to the status word clears irq_o, the index and all pending bits; a matching write in the same cycle as the clear is recorded as a fresh first event.
- R10: After reset all registers, status, irq_o, out_valid_o, out_sector_o and out_cipher_o are zero.
- R11: Register map (word address): slot s at 4*s+0 start, 4*s+1 length, 4*s+2 base; 4*NUM_SLOTS+0 cipher start, +1 cipher length, +2 status. Status bit 0 = irq pending, bits [7:4] = recorded slot index, bits [8+NUM_SLOTS-1:8] = per-slot pending mask. Configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | SECT_W | Register write data |
| reg_rdata_o | output | SECT_W | Register read data (combinational) |
| req_i | input | 1 | Access request strobe |
| req_we_i | input | 1 | Access is a write when 1 |
| req_sector_i | input | SECT_W | Requested sector |
| out_valid_o | output | 1 | Translated result valid |
| out_sector_o | output | SECT_W | Translated sector |
| out_cipher_o | output | 1 | Translated sector is in the cipher range |
| irq_o | output | 1 | Write-to-relocated-slot interrupt |

## Verification
A directed layout with two overlapping windows, a disabled slot, a one-sector slot and a cipher range that ends inside a relocated copy is probed at the first and last sectors of each window and one past them. This separates off-by-one range errors, priority order and a disabled slot that still matches. Reads and writes to the same sectors tell remapping apart from interrupt generation. A clear issued together with a hit shows which of the two wins. Constrained-random configurations with small, often overlapping windows then mix reads, writes and clears against a bench model of the translation and of the sticky status.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int FLD_START = 0;
  localparam int FLD_LEN   = 1;
  localparam int FLD_BASE  = 2;
  localparam int FLD_CSTART = 0;
  localparam int FLD_CLEN   = 1;
  localparam int FLD_STAT   = 2;
  localparam int STAT_IRQ_BIT = 0;
  localparam int STAT_IDX_LSB = 4;
  localparam int STAT_MASK_LSB = 8;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SECT_W    = 32,
  parameter int IW        = 2,
  parameter int AW        = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [AW-1:0]                    addr_i,
  input  logic [SECT_W-1:0]                wdata_i,
  output logic [SECT_W-1:0]                rdata_o,
  input  logic                             irq_i,
  input  logic [IW-1:0]                    idx_i,
  input  logic [NUM_SLOTS-1:0]             mask_i,
  output logic [NUM_SLOTS-1:0][SECT_W-1:0] start_o,
  output logic [NUM_SLOTS-1:0][SECT_W-1:0] len_o,
  output logic [NUM_SLOTS-1:0][SECT_W-1:0] base_o,
  output logic [SECT_W-1:0]                cstart_o,
  output logic [SECT_W-1:0]                clen_o,
  output logic                             clr_o
);
  localparam int GW = AW - 2;

  logic [GW-1:0] grp;
  logic [1:0]    fld;
  logic          glob;
  logic [SECT_W-1:0] stat_word;

  assign grp  = addr_i[AW-1:2];
  assign fld  = addr_i[1:0];
  assign glob = (int'(grp) == NUM_SLOTS);
  assign clr_o = we_i && glob && (int'(fld) == FLD_STAT);

  always_comb begin
    stat_word = '0;
    stat_word[STAT_IRQ_BIT] = irq_i;
    stat_word[STAT_IDX_LSB +: IW] = idx_i;
    stat_word[STAT_MASK_LSB +: NUM_SLOTS] = mask_i;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic sel;
    assign sel = we_i && (int'(grp) == s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_o[s] <= '0;
        len_o[s]   <= '0;
        base_o[s]  <= '0;
      end else if (sel) begin
        if (int'(fld) == FLD_START) start_o[s] <= wdata_i;
        if (int'(fld) == FLD_LEN)   len_o[s]   <= wdata_i;
        if (int'(fld) == FLD_BASE)  base_o[s]  <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cstart_o <= '0;
      clen_o   <= '0;
    end else if (we_i && glob) begin
      if (int'(fld) == FLD_CSTART) cstart_o <= wdata_i;
      if (int'(fld) == FLD_CLEN)   clen_o   <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(grp) < NUM_SLOTS) begin
      case (int'(fld))
        FLD_START: rdata_o = start_o[grp];
        FLD_LEN:   rdata_o = len_o[grp];
        FLD_BASE:  rdata_o = base_o[grp];
        default:   rdata_o = '0;
      endcase
    end else if (glob) begin
      case (int'(fld))
        FLD_CSTART: rdata_o = cstart_o;
        FLD_CLEN:   rdata_o = clen_o;
        FLD_STAT:   rdata_o = stat_word;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/remap_slot_match.sv
module remap_slot_match #(
  parameter int NUM_SLOTS = 4,
  parameter int SECT_W    = 32,
  parameter int IW        = 2
) (
  input  logic [SECT_W-1:0]                sector_i,
  input  logic [NUM_SLOTS-1:0][SECT_W-1:0] start_i,
  input  logic [NUM_SLOTS-1:0][SECT_W-1:0] len_i,
  input  logic [NUM_SLOTS-1:0][SECT_W-1:0] base_i,
  input  logic [SECT_W-1:0]                cstart_i,
  input  logic [SECT_W-1:0]                clen_i,
  output logic                             hit_o,
  output logic [IW-1:0]                    idx_o,
  output logic [SECT_W-1:0]                xlat_o,
  output logic                             cipher_o
);
  logic [NUM_SLOTS-1:0][SECT_W-1:0] rel;
  logic [NUM_SLOTS-1:0]             hv;
  logic [SECT_W-1:0]                crel;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    assign rel[s] = sector_i - start_i[s];
    assign hv[s]  = (len_i[s] != '0) && (sector_i >= start_i[s]) && (rel[s] < len_i[s]);
  end

  // scan downward so the lowest matching slot is left selected
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hv[s]) begin
        hit_o = 1'b1;
        idx_o = IW'(s);
      end
    end
  end

  assign xlat_o   = hit_o ? (base_i[idx_o] + rel[idx_o]) : sector_i;
  assign crel     = xlat_o - cstart_i;
  assign cipher_o = (clen_i != '0) && (xlat_o >= cstart_i) && (crel < clen_i);
endmodule

// File: rtl/remap_irq_ctrl.sv
module remap_irq_ctrl #(
  parameter int NUM_SLOTS = 4,
  parameter int IW        = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_hit_i,
  input  logic [IW-1:0]        hit_idx_i,
  input  logic                 clr_i,
  output logic                 irq_o,
  output logic [IW-1:0]        idx_o,
  output logic [NUM_SLOTS-1:0] mask_o
);
  logic                 irq_base;
  logic [NUM_SLOTS-1:0] mask_base;

  // a clear in the same cycle as a hit is applied first
  assign irq_base  = clr_i ? 1'b0 : irq_o;
  assign mask_base = clr_i ? '0 : mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      idx_o  <= '0;
      mask_o <= '0;
    end else begin
      irq_o  <= irq_base | wr_hit_i;
      mask_o <= mask_base | (wr_hit_i ? (NUM_SLOTS'(1) << hit_idx_i) : '0);
      if (clr_i) idx_o <= '0;
      if (wr_hit_i && !irq_base) idx_o <= hit_idx_i;
    end
  end

  // R8
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
  // R8
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> $stable(idx_o));
  // R7
  irq_has_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_o != '0) && mask_o[idx_o]);
  // R9
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !wr_hit_i |=> !irq_o && (mask_o == '0));
endmodule

// File: rtl/sector_remap_unit.sv
module sector_remap_unit #(
  parameter int NUM_SLOTS = 4,
  parameter int SECT_W    = 32,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int AW = $clog2(NUM_SLOTS + 1) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [SECT_W-1:0] reg_wdata_i,
  output logic [SECT_W-1:0] reg_rdata_o,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [SECT_W-1:0] req_sector_i,
  output logic              out_valid_o,
  output logic [SECT_W-1:0] out_sector_o,
  output logic              out_cipher_o,
  output logic              irq_o
);
  logic [NUM_SLOTS-1:0][SECT_W-1:0] slot_start, slot_len, slot_base;
  logic [SECT_W-1:0]    ciph_start, ciph_len, xlat;
  logic                 hit, cipher, clr;
  logic [IW-1:0]        hit_idx, irq_idx;
  logic [NUM_SLOTS-1:0] pend_mask;

  remap_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .SECT_W(SECT_W), .IW(IW), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .irq_i(irq_o), .idx_i(irq_idx), .mask_i(pend_mask),
    .start_o(slot_start), .len_o(slot_len), .base_o(slot_base),
    .cstart_o(ciph_start), .clen_o(ciph_len), .clr_o(clr)
  );

  remap_slot_match #(.NUM_SLOTS(NUM_SLOTS), .SECT_W(SECT_W), .IW(IW)) u_match (
    .sector_i(req_sector_i), .start_i(slot_start), .len_i(slot_len), .base_i(slot_base),
    .cstart_i(ciph_start), .clen_i(ciph_len),
    .hit_o(hit), .idx_o(hit_idx), .xlat_o(xlat), .cipher_o(cipher)
  );

  remap_irq_ctrl #(.NUM_SLOTS(NUM_SLOTS), .IW(IW)) u_irq (
    .clk_i, .rst_ni,
    .wr_hit_i(req_i && req_we_i && hit), .hit_idx_i(hit_idx), .clr_i(clr),
    .irq_o(irq_o), .idx_o(irq_idx), .mask_o(pend_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_sector_o <= '0;
      out_cipher_o <= 1'b0;
    end else begin
      out_valid_o <= req_i;
      if (req_i) begin
        out_sector_o <= xlat;
        out_cipher_o <= cipher;
      end
    end
  end

  // R5
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> out_valid_o);
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !out_valid_o && $stable(out_sector_o) && $stable(out_cipher_o));
  // R4
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !hit |=> out_sector_o == $past(req_sector_i));
  // R7
  read_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !(req_i && req_we_i) |=> !irq_o);
endmodule

// File: tb/sector_remap_unit_tb.sv
module sector_remap_unit_tb;
  localparam int NS = 4;
  localparam int W  = 32;
  localparam int AW = 5;
  localparam int CIPH = 4 * NS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic req = 1'b0, req_we = 1'b0;
  logic [W-1:0] req_sector = '0, out_sector;
  logic out_valid, out_cipher, irq;

  int n_chk = 0, n_err = 0;
  logic [W-1:0] m_start [NS], m_len [NS], m_base [NS];
  logic [W-1:0] m_cstart = '0, m_clen = '0;
  logic m_irq = 1'b0;
  int   m_idx = 0;
  logic [NS-1:0] m_mask = '0;

  always #2 clk = ~clk;

  sector_remap_unit #(.NUM_SLOTS(NS), .SECT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_i(req), .req_we_i(req_we), .req_sector_i(req_sector),
    .out_valid_o(out_valid), .out_sector_o(out_sector), .out_cipher_o(out_cipher), .irq_o(irq)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_slot(logic [W-1:0] s);
    for (int i = 0; i < NS; i++)
      if (m_len[i] != 0 && s >= m_start[i] && (s - m_start[i]) < m_len[i]) return i;
    return -1;
  endfunction

  function automatic logic [W-1:0] model_xlat(logic [W-1:0] s);
    int k = model_slot(s);
    return (k < 0) ? s : m_base[k] + (s - m_start[k]);
  endfunction

  function automatic logic model_ciph(logic [W-1:0] t);
    return m_clen != 0 && t >= m_cstart && (t - m_cstart) < m_clen;
  endfunction

  function automatic logic [W-1:0] model_stat();
    logic [W-1:0] v = '0;
    v[0] = m_irq;
    v[7:4] = 4'(m_idx);
    v[8 +: NS] = m_mask;
    return v;
  endfunction

  task automatic model_hit(bit wr, logic [W-1:0] s);
    int k = model_slot(s);
    if (wr && k >= 0) begin
      if (!m_irq) begin m_irq = 1'b1; m_idx = k; end
      m_mask[k] = 1'b1;
    end
  endtask

  task automatic model_clear();
    m_irq = 1'b0; m_idx = 0; m_mask = '0;
  endtask

  task automatic reg_wr(int a, logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(int a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_slot(int i, logic [W-1:0] st, logic [W-1:0] ln, logic [W-1:0] bs);
    reg_wr(4*i, st); reg_wr(4*i+1, ln); reg_wr(4*i+2, bs);
    m_start[i] = st; m_len[i] = ln; m_base[i] = bs;
  endtask

  task automatic set_ciph(logic [W-1:0] st, logic [W-1:0] ln);
    reg_wr(CIPH, st); reg_wr(CIPH+1, ln);
    m_cstart = st; m_clen = ln;
  endtask

  task automatic clear_stat(string tag);
    logic [W-1:0] d;
    reg_wr(CIPH+2, '0);
    model_clear();
    reg_rd(CIPH+2, d);
    check({tag, " status after clear"}, d, model_stat());
    check({tag, " irq after clear"}, W'(irq), W'(m_irq));
  endtask

  // one access, then outputs, irq and status compared with the model
  task automatic access(string tag, bit wr, logic [W-1:0] s, bit with_clr = 1'b0);
    logic [W-1:0] exp_x, d;
    exp_x = model_xlat(s);
    @(negedge clk);
    req = 1'b1; req_we = wr; req_sector = s;
    if (with_clr) begin reg_we = 1'b1; reg_addr = AW'(CIPH+2); end
    @(negedge clk);
    req = 1'b0; reg_we = 1'b0;
    if (with_clr) model_clear();
    model_hit(wr, s);
    check({tag, " valid"}, W'(out_valid), 1);
    check({tag, " sector"}, out_sector, exp_x);
    check({tag, " cipher"}, W'(out_cipher), W'(model_ciph(exp_x)));
    check({tag, " irq"}, W'(irq), W'(m_irq));
    reg_rd(CIPH+2, d);
    check({tag, " status"}, d, model_stat());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] d;
    int seed;
    seed = $urandom(32'h5ec7);
    for (int i = 0; i < NS; i++) begin m_start[i] = '0; m_len[i] = '0; m_base[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 valid", W'(out_valid), 0);
    check("R10 sector", out_sector, 0);
    check("R10 cipher", W'(out_cipher), 0);
    check("R10 irq", W'(irq), 0);
    reg_rd(CIPH+2, d); check("R10 status", d, 0);
    reg_rd(1, d);      check("R10 slot0 len", d, 0);

    set_slot(0, 100, 10, 1000);
    set_slot(1, 105, 10, 2000);
    set_slot(2, 300, 0, 3000);
    set_slot(3, 500, 1, 7);
    set_ciph(1000, 8);
    // R11 readback
    reg_rd(4, d);      check("R11 slot1 start", d, 105);
    reg_rd(14, d);     check("R11 slot3 base", d, 7);
    reg_rd(CIPH+1, d); check("R11 cipher len", d, 8);

    access("R1 R6 R7 read first sector", 0, 100);
    access("R1 R6 last sector past cipher end", 0, 109);
    access("R3 R1 overlap lower slot wins", 0, 105);
    access("R3 one past slot0 falls to slot1", 0, 110);
    access("R4 below all slots", 0, 99);
    access("R2 zero length slot ignored", 0, 300);
    access("R1 R4 one past slot3", 1, 501);
    access("R7 write hit slot3", 1, 500);
    access("R8 second write hit slot0", 1, 106);
    access("R8 write outside slots", 1, 50);
    access("R7 R8 read inside slot while pending", 0, 112);
    clear_stat("R9");
    access("R9 clear with same cycle hit", 1, 112, 1'b1);
    clear_stat("R9 second");
    access("R7 R5 read leaves irq low", 0, 501);
    set_ciph(1000, 0);
    access("R6 zero cipher length", 0, 100);
    set_ciph(95, 10);
    access("R6 untranslated sector ciphered", 0, 96);
    access("R6 cipher range end", 0, 105);
    @(negedge clk);
    check("R5 valid drops when idle", W'(out_valid), 0);
    clear_stat("R9 pre-random");

    for (int it = 0; it < 600; it++) begin
      if (it % 60 == 0) begin
        for (int i = 0; i < NS; i++)
          set_slot(i, W'($urandom_range(0, 200)), W'($urandom_range(0, 40)),
                   W'($urandom_range(0, 3)) << 10);
        set_ciph(W'($urandom_range(0, 4000)), W'($urandom_range(0, 600)));
      end
      case ($urandom_range(0, 9))
        0: clear_stat("R9 random");
        1: access("R9 R8 random clear with access", $urandom_range(0, 1) == 1,
                  W'($urandom_range(0, 255)), 1'b1);
        default: access("R1 R3 R4 R6 R8 random", $urandom_range(0, 1) == 1,
                        W'($urandom_range(0, 255)));
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule